// File: doc/BRIEF.md
# Code Block Segmenter With Per-Block CRC24B

This block receives a transport block that already carries its own CRC as a serial bit stream. It decides whether that block fits one decoder input or must be split. From the payload length, the CRC length and two code-rate flags, it picks one of two maximum block sizes. It then works out how many code blocks are needed and how long each one is. The split is reported before any data moves. A sequential divider does both divisions, and a valid flag marks the results once they are ready.

Once the sizes are known, the block accepts input bits through a valid/ready handshake and forwards them one per cycle. With segmentation, each code block carries its share of the input bits and then 24 parity bits. Those parity bits come from a CRC register that restarts at zero for every block. The input is held off while the parity bits go out. Start-of-block and end-of-block markers frame every code block on the output.

Top module: `cbs_segmenter`

## Requirements
- R1: `bg1_sel` is 1 when (payload length > SMALL_L and `rate_hi`) or (payload length > BIG_L and `rate_mid`), and 0 otherwise. The maximum block size M is BG1_MAX when `bg1_sel` is 1 and BG2_MAX when it is 0.
- R2: When B = payload length + CRC length is not above M, `num_cb` is 1 and `cb_size` equals B.
- R3: When B exceeds M, `num_cb` equals the ceiling of B / (M - 24), and `cb_size` never exceeds M.
- R4: When B exceeds M, `cb_size` equals B / `num_cb` + 24.
- R5: `params_valid` goes high no later than 2*LEN_W+6 cycles after an accepted `start`. `in_ready` is never high while `params_valid` is low.
- R6: Data bit j of code block i on the output is input bit i*(cb_size-24)+j, and bits keep their input order.
- R7: With segmentation, each code block ends with 24 parity bits, sent most significant first. They are the remainder of the block's data bits times x^24, divided by x^24+x^23+x^6+x^5+x+1. The remainder register starts from zero at every block.
- R8: Without segmentation, the output is exactly the B input bits with no parity appended.
- R9: `in_ready` is low throughout the 24 parity cycles of a block, and a parity run never lasts longer than 24 cycles.
- R10: `out_sop` marks the first bit and `out_eop` the last bit of each code block, so each block is `cb_size` bits long. The output after `out_eop` is either absent or a new `out_sop`.
- R11: `start` has no effect unless `cfg_ready` is high. `num_cb` and `cb_size` stay unchanged while `params_valid` is high.
- R12: After reset, `cfg_ready` is 1, and `params_valid`, `in_ready` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transport block (taken when cfg_ready) |
| tb_len | input | LEN_W | Payload length without its CRC |
| crc_len | input | NW | Length of the attached transport block CRC |
| rate_hi | input | 1 | Code rate above 0.67 |
| rate_mid | input | 1 | Code rate above 0.25 |
| cfg_ready | output | 1 | Idle, a start will be taken |
| params_valid | output | 1 | bg1_sel, num_cb and cb_size are valid |
| bg1_sel | output | 1 | Larger block size selected |
| num_cb | output | LEN_W | Number of code blocks |
| cb_size | output | LEN_W | Code block length including its parity |
| in_valid | input | 1 | Input bit present |
| in_bit | input | 1 | Input bit |
| in_ready | output | 1 | Input bit accepted this cycle when valid |
| out_valid | output | 1 | Output bit present |
| out_bit | output | 1 | Output bit |
| out_sop | output | 1 | First bit of a code block |
| out_eop | output | 1 | Last bit of a code block |

## Verification
Each output bit appears one cycle after the cycle that produced it: an accepted input bit, or a cycle of the parity phase. The bench therefore drives inputs at falling edges and reads the outputs at the next falling edge. It tags every output with the ready level it saw one cycle earlier, so each parity bit can be checked against a stalled input. The size results can take up to two divider passes. The bench counts falling edges from `start` until `params_valid` rises, compares that count with the R5 bound, and only then checks `num_cb` and `cb_size`.

The bench sweeps every payload length from 1 to 150 under all four rate-flag combinations, using a reduced size configuration, and skips only lengths that do not divide evenly into blocks. Irregular input bubbles vary the accept pattern from case to case.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int CRC_W = 24;
  localparam logic [CRC_W-1:0] CRC24B_POLY = 24'h800063;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SIZE,
    ST_DATA,
    ST_PAR
  } seg_state_e;

  typedef enum logic [1:0] {
    SZ_IDLE,
    SZ_CHECK,
    SZ_DIV1,
    SZ_DIV2
  } sz_state_e;
endpackage

// File: rtl/cbs_seq_div.sv
module cbs_seq_div #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_d;
  logic [W:0]    rem_q, rem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;

  always_comb begin
    quo_d   = quo_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    diff    = {1'b0, shifted} - {2'b00, divisor};
    if (start) begin
      quo_d = dividend;
      rem_d = '0;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      if (!diff[W+1]) begin
        rem_d = diff[W:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = shifted;
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;
endmodule

// File: rtl/cbs_sizer.sv
module cbs_sizer
  import cbs_pkg::*;
#(
  parameter int LEN_W   = 21,
  parameter int NW      = 5,
  parameter int BG1_MAX = 8448,
  parameter int BG2_MAX = 3840,
  parameter int SMALL_L = 292,
  parameter int BIG_L   = 3824
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len_tb,
  input  logic [NW-1:0]    len_crc,
  input  logic             rate_hi,
  input  logic             rate_mid,
  output logic             done,
  output logic             bg1,
  output logic             seg,
  output logic [LEN_W-1:0] num_cb,
  output logic [LEN_W-1:0] cb_size,
  output logic [LEN_W-1:0] cb_data
);
  localparam logic [LEN_W-1:0] M1      = LEN_W'(BG1_MAX);
  localparam logic [LEN_W-1:0] M2      = LEN_W'(BG2_MAX);
  localparam logic [LEN_W-1:0] SMALL_T = LEN_W'(SMALL_L);
  localparam logic [LEN_W-1:0] BIG_T   = LEN_W'(BIG_L);
  localparam logic [LEN_W-1:0] PAR_LEN = LEN_W'(CRC_W);

  sz_state_e        st_q, st_d;
  logic [LEN_W-1:0] b_q, b_d;
  logic             bg1_q, bg1_d;
  logic             seg_q, seg_d;
  logic [LEN_W-1:0] c_q, c_d;
  logic [LEN_W-1:0] d_q, d_d;
  logic [LEN_W-1:0] k_q, k_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] m_sel;
  logic             dv_start, dv_done;
  logic [LEN_W-1:0] dv_dividend, dv_divisor, dv_quo;

  assign m_sel       = bg1_q ? M1 : M2;
  assign dv_dividend = (st_q == SZ_DIV1) ? b_q : (b_q + m_sel - PAR_LEN - 1'b1);
  assign dv_divisor  = (st_q == SZ_DIV2) ? c_q : (m_sel - PAR_LEN);

  cbs_seq_div #(.W(LEN_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (dv_start),
    .dividend (dv_dividend),
    .divisor  (dv_divisor),
    .done     (dv_done),
    .quotient (dv_quo)
  );

  always_comb begin
    st_d     = st_q;
    b_d      = b_q;
    bg1_d    = bg1_q;
    seg_d    = seg_q;
    c_d      = c_q;
    d_d      = d_q;
    k_d      = k_q;
    done_d   = 1'b0;
    dv_start = 1'b0;
    unique case (st_q)
      SZ_IDLE: begin
        if (start) begin
          b_d   = len_tb + LEN_W'(len_crc);
          bg1_d = ((len_tb > SMALL_T) && rate_hi) || ((len_tb > BIG_T) && rate_mid);
          st_d  = SZ_CHECK;
        end
      end
      SZ_CHECK: begin
        if (b_q <= m_sel) begin
          c_d    = LEN_W'(1);
          d_d    = b_q;
          k_d    = b_q;
          seg_d  = 1'b0;
          done_d = 1'b1;
          st_d   = SZ_IDLE;
        end else begin
          seg_d    = 1'b1;
          dv_start = 1'b1;
          st_d     = SZ_DIV1;
        end
      end
      SZ_DIV1: begin
        if (dv_done) begin
          c_d      = dv_quo;
          dv_start = 1'b1;
          st_d     = SZ_DIV2;
        end
      end
      SZ_DIV2: begin
        if (dv_done) begin
          d_d    = dv_quo;
          k_d    = dv_quo + PAR_LEN;
          done_d = 1'b1;
          st_d   = SZ_IDLE;
        end
      end
      default: st_d = SZ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SZ_IDLE;
      b_q    <= '0;
      bg1_q  <= 1'b0;
      seg_q  <= 1'b0;
      c_q    <= '0;
      d_q    <= '0;
      k_q    <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      b_q    <= b_d;
      bg1_q  <= bg1_d;
      seg_q  <= seg_d;
      c_q    <= c_d;
      d_q    <= d_d;
      k_q    <= k_d;
      done_q <= done_d;
    end
  end

  assign done    = done_q;
  assign bg1     = bg1_q;
  assign seg     = seg_q;
  assign num_cb  = c_q;
  assign cb_size = k_q;
  assign cb_data = d_q;
endmodule

// File: rtl/cbs_crc24b.sv
module cbs_crc24b
  import cbs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic first,
  input  logic drain,
  input  logic din,
  output logic msb
);
  logic [CRC_W-1:0] crc_q, crc_d, base;
  logic             fb;

  always_comb begin
    base = first ? '0 : crc_q;
    fb   = din ^ base[CRC_W-1];
    if (drain) begin
      crc_d = {base[CRC_W-2:0], 1'b0};
    end else begin
      crc_d = {base[CRC_W-2:0], 1'b0} ^ (fb ? CRC24B_POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '0;
    end else if (en) begin
      crc_q <= crc_d;
    end
  end

  assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/cbs_segmenter.sv
module cbs_segmenter
  import cbs_pkg::*;
#(
  parameter int LEN_W   = 21,
  parameter int NW      = 5,
  parameter int BG1_MAX = 8448,
  parameter int BG2_MAX = 3840,
  parameter int SMALL_L = 292,
  parameter int BIG_L   = 3824
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] tb_len,
  input  logic [NW-1:0]    crc_len,
  input  logic             rate_hi,
  input  logic             rate_mid,
  output logic             cfg_ready,
  output logic             params_valid,
  output logic             bg1_sel,
  output logic [LEN_W-1:0] num_cb,
  output logic [LEN_W-1:0] cb_size,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_sop,
  output logic             out_eop
);
  localparam int PW = $clog2(CRC_W);
  localparam logic [PW-1:0] PAR_LAST = PW'(CRC_W - 1);

  seg_state_e       st_q, st_d;
  logic             pv_q, pv_d;
  logic [LEN_W-1:0] bit_q, bit_d;
  logic [LEN_W-1:0] blk_q, blk_d;
  logic [PW-1:0]    par_q, par_d;
  logic             ov_q, ov_d, ob_q, ob_d, os_q, os_d, oe_q, oe_d;

  logic             sz_start, sz_done, sz_bg1, sz_seg;
  logic [LEN_W-1:0] sz_c, sz_k, sz_d;
  logic             crc_en, crc_first, crc_drain, crc_msb;
  logic             last_data, last_blk, last_par;

  cbs_sizer #(
    .LEN_W(LEN_W), .NW(NW), .BG1_MAX(BG1_MAX), .BG2_MAX(BG2_MAX),
    .SMALL_L(SMALL_L), .BIG_L(BIG_L)
  ) u_sizer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (sz_start),
    .len_tb   (tb_len),
    .len_crc  (crc_len),
    .rate_hi  (rate_hi),
    .rate_mid (rate_mid),
    .done     (sz_done),
    .bg1      (sz_bg1),
    .seg      (sz_seg),
    .num_cb   (sz_c),
    .cb_size  (sz_k),
    .cb_data  (sz_d)
  );

  cbs_crc24b u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (crc_en),
    .first (crc_first),
    .drain (crc_drain),
    .din   (in_bit),
    .msb   (crc_msb)
  );

  assign in_ready  = (st_q == ST_DATA);
  assign cfg_ready = (st_q == ST_IDLE);
  assign last_data = (bit_q == sz_d - 1'b1);
  assign last_blk  = (blk_q == sz_c - 1'b1);
  assign last_par  = (par_q == PAR_LAST);

  always_comb begin
    st_d      = st_q;
    pv_d      = pv_q;
    bit_d     = bit_q;
    blk_d     = blk_q;
    par_d     = par_q;
    ov_d      = 1'b0;
    ob_d      = ob_q;
    os_d      = 1'b0;
    oe_d      = 1'b0;
    sz_start  = 1'b0;
    crc_en    = 1'b0;
    crc_first = (bit_q == '0);
    crc_drain = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          sz_start = 1'b1;
          pv_d     = 1'b0;
          st_d     = ST_SIZE;
        end
      end
      ST_SIZE: begin
        if (sz_done) begin
          pv_d  = 1'b1;
          bit_d = '0;
          blk_d = '0;
          st_d  = ST_DATA;
        end
      end
      ST_DATA: begin
        if (in_valid) begin
          crc_en = 1'b1;
          ov_d   = 1'b1;
          ob_d   = in_bit;
          os_d   = (bit_q == '0);
          oe_d   = last_data && !sz_seg;
          if (last_data) begin
            bit_d = '0;
            par_d = '0;
            st_d  = sz_seg ? ST_PAR : ST_IDLE;
          end else begin
            bit_d = bit_q + 1'b1;
          end
        end
      end
      ST_PAR: begin
        crc_en    = 1'b1;
        crc_first = 1'b0;
        crc_drain = 1'b1;
        ov_d      = 1'b1;
        ob_d      = crc_msb;
        oe_d      = last_par;
        par_d     = par_q + 1'b1;
        if (last_par) begin
          if (last_blk) begin
            st_d = ST_IDLE;
          end else begin
            blk_d = blk_q + 1'b1;
            st_d  = ST_DATA;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      pv_q  <= 1'b0;
      bit_q <= '0;
      blk_q <= '0;
      par_q <= '0;
      ov_q  <= 1'b0;
      ob_q  <= 1'b0;
      os_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      pv_q  <= pv_d;
      bit_q <= bit_d;
      blk_q <= blk_d;
      par_q <= par_d;
      ov_q  <= ov_d;
      ob_q  <= ob_d;
      os_q  <= os_d;
      oe_q  <= oe_d;
    end
  end

  assign params_valid = pv_q;
  assign bg1_sel      = sz_bg1;
  assign num_cb       = sz_c;
  assign cb_size      = sz_k;
  assign out_valid    = ov_q;
  assign out_bit      = ob_q;
  assign out_sop      = os_q;
  assign out_eop      = oe_q;
endmodule

// File: rtl/cbs_segmenter_chk.sv
module cbs_segmenter_chk #(
  parameter int LEN_W   = 21,
  parameter int NW      = 5,
  parameter int BG1_MAX = 8448,
  parameter int BG2_MAX = 3840
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] tb_len,
  input logic [NW-1:0]    crc_len,
  input logic             rate_hi,
  input logic             rate_mid,
  input logic             cfg_ready,
  input logic             params_valid,
  input logic             bg1_sel,
  input logic [LEN_W-1:0] num_cb,
  input logic [LEN_W-1:0] cb_size,
  input logic             in_valid,
  input logic             in_bit,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_bit,
  input logic             out_sop,
  input logic             out_eop
);
  localparam logic [LEN_W-1:0] M1  = LEN_W'(BG1_MAX);
  localparam logic [LEN_W-1:0] M2  = LEN_W'(BG2_MAX);
  localparam logic [LEN_W-1:0] PL  = LEN_W'(24);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic       prev_rdy;
  logic [5:0] par_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_rdy <= 1'b0;
      par_run  <= '0;
    end else begin
      prev_rdy <= in_ready;
      if (out_valid && !prev_rdy) begin
        par_run <= par_run + 1'b1;
      end else begin
        par_run <= '0;
      end
    end
  end

  AST_RDY_NEEDS_PARAMS: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> params_valid); // R5
  AST_IDLE_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> !in_ready); // R11
  AST_PARITY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    par_run <= 6'd24); // R9
  AST_K_ABOVE_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (params_valid && num_cb != ONE) |-> cb_size > PL); // R4
  AST_K_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (params_valid && num_cb != ONE) |-> cb_size <= (bg1_sel ? M1 : M2)); // R3
  AST_PARAMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (params_valid && $past(params_valid)) |-> ($stable(num_cb) && $stable(cb_size))); // R11
  AST_EOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> (!out_valid || out_sop)); // R10
endmodule

bind cbs_segmenter cbs_segmenter_chk #(
  .LEN_W(LEN_W), .NW(NW), .BG1_MAX(BG1_MAX), .BG2_MAX(BG2_MAX)
) u_chk (.*);

// File: tb/tb_cbs_segmenter.sv
`timescale 1ns/1ps
module tb_cbs_segmenter;
  localparam int LW = 10;
  localparam int NWB = 5;
  localparam int G1 = 96;
  localparam int G2 = 64;
  localparam int SL = 20;
  localparam int BL = 48;

  logic clk, rst_n, start, rate_hi, rate_mid, in_valid, in_bit;
  logic [LW-1:0] tb_len;
  logic [NWB-1:0] crc_len;
  logic cfg_ready, params_valid, bg1_sel, in_ready;
  logic [LW-1:0] num_cb, cb_size;
  logic out_valid, out_bit, out_sop, out_eop;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] lfsr = 32'h1ACE_B00C;

  bit data_a [0:255];
  bit exp_b [0:511];
  bit exp_s [0:511];
  bit exp_e [0:511];
  bit exp_p [0:511];
  bit got_b [0:511];
  bit got_s [0:511];
  bit got_e [0:511];
  bit got_r [0:511];

  cbs_segmenter #(
    .LEN_W(LW), .NW(NWB), .BG1_MAX(G1), .BG2_MAX(G2), .SMALL_L(SL), .BIG_L(BL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .tb_len(tb_len), .crc_len(crc_len),
    .rate_hi(rate_hi), .rate_mid(rate_mid), .cfg_ready(cfg_ready),
    .params_valid(params_valid), .bg1_sel(bg1_sel), .num_cb(num_cb),
    .cb_size(cb_size), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_bit(out_bit), .out_sop(out_sop), .out_eop(out_eop)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      checks = checks + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run did not finish, got %0d cycles expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit nextbit();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr[0];
  endfunction

  // remainder of (data[base..base+len-1] * x^24) mod x^24+x^23+x^6+x^5+x+1
  function automatic logic [23:0] ref_crc(input int base, input int len);
    bit msg [0:159];
    logic [24:0] g;
    logic [23:0] r;
    g = 25'h1800063;
    for (int i = 0; i < len + 24; i++) msg[i] = (i < len) ? data_a[base + i] : 1'b0;
    for (int i = 0; i < len; i++) begin
      if (msg[i]) begin
        for (int k = 0; k < 25; k++) msg[i + k] = msg[i + k] ^ g[24 - k];
      end
    end
    for (int k = 0; k < 24; k++) r[23 - k] = msg[len + k];
    return r;
  endfunction

  task automatic run_case(input int l, input bit hi, input bit mid, input bit poke);
    int n, b, m, c, d, k, blen, total, cnt, got, idx, guard;
    bit bg1, seg, rdy_early, prev_rdy, poked, ok;
    logic [23:0] cr;
    n = (l > BL) ? 24 : 16;
    b = l + n;
    bg1 = ((l > SL) && hi) || ((l > BL) && mid);
    m = bg1 ? G1 : G2;
    seg = (b > m);
    c = seg ? (b + m - 25) / (m - 24) : 1;
    if ((b % c) != 0) return;
    d = b / c;
    k = seg ? d + 24 : b;
    blen = k;
    total = c * blen;

    tb_len = LW'(l); crc_len = NWB'(n); rate_hi = hi; rate_mid = mid; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    rdy_early = 1'b0;
    while (!params_valid && cnt < 200) begin
      if (in_ready) rdy_early = 1'b1;
      @(negedge clk);
      cnt++;
    end
    chk(cnt <= 2 * LW + 6, "R5 params latency", cnt, 2 * LW + 6);
    chk(!rdy_early, "R5 ready before params", int'(rdy_early), 0);
    chk(bg1_sel == bg1, "R1 base graph", int'(bg1_sel), int'(bg1));
    if (seg) begin
      chk(int'(num_cb) == c, "R3 block count", int'(num_cb), c);
      chk(int'(cb_size) == k, "R4 block size", int'(cb_size), k);
    end else begin
      chk(int'(num_cb) == 1 && int'(cb_size) == b, "R2 unsegmented size",
          int'(cb_size), b);
    end

    for (int i = 0; i < b; i++) data_a[i] = nextbit();
    for (int i = 0; i < c; i++) begin
      cr = seg ? ref_crc(i * d, d) : 24'h0;
      for (int j = 0; j < blen; j++) begin
        exp_b[i * blen + j] = (j < d) ? data_a[i * d + j] : cr[23 - (j - d)];
        exp_p[i * blen + j] = (j >= d);
        exp_s[i * blen + j] = (j == 0);
        exp_e[i * blen + j] = (j == blen - 1);
      end
    end

    got = 0; idx = 0; guard = 0; prev_rdy = 1'b0; poked = 1'b0;
    while (got < total && guard < 2000) begin
      if (out_valid && got < 512) begin
        got_b[got] = out_bit; got_s[got] = out_sop; got_e[got] = out_eop;
        got_r[got] = prev_rdy;
        got++;
      end
      prev_rdy = in_ready;
      if (in_ready && idx < b && (guard % 7) != 3) begin
        in_valid = 1'b1; in_bit = data_a[idx]; idx++;
      end else begin
        in_valid = 1'b0;
      end
      if (poke && !poked && idx == 5) begin
        start = 1'b1; tb_len = LW'(3); poked = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    in_valid = 1'b0; start = 1'b0;
    chk(got == total, seg ? "R10 output length" : "R8 output length", got, total);

    for (int i = 0; i < c; i++) begin
      int bad_d, bad_p, bad_m, bad_s;
      bad_d = 0; bad_p = 0; bad_m = 0; bad_s = 0;
      for (int j = 0; j < blen; j++) begin
        int p;
        p = i * blen + j;
        if (got_b[p] != exp_b[p]) begin
          if (exp_p[p]) bad_p++; else bad_d++;
        end
        if (got_s[p] != exp_s[p] || got_e[p] != exp_e[p]) bad_m++;
        if (got_r[p] == exp_p[p]) bad_s++;
      end
      chk(bad_d == 0, seg ? "R6 data bits" : "R8 passthrough bits", bad_d, 0);
      if (seg) begin
        chk(bad_p == 0, "R7 parity bits", bad_p, 0);
        chk(bad_s == 0, "R9 stall during parity", bad_s, 0);
      end
      chk(bad_m == 0, "R10 block markers", bad_m, 0);
    end

    repeat (3) @(negedge clk);
    chk(!out_valid && cfg_ready, "R10 quiet after stream", int'(out_valid), 0);
    if (poke) begin
      chk(int'(num_cb) == c && params_valid, "R11 start ignored while busy",
          int'(num_cb), c);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; tb_len = '0; crc_len = '0;
    rate_hi = 1'b0; rate_mid = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg_ready && !params_valid && !in_ready && !out_valid, "R12 reset state",
        int'({cfg_ready, params_valid, in_ready, out_valid}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    run_case(120, 1'b1, 1'b1, 1'b1);
    run_case(60, 1'b0, 1'b0, 1'b1);
    for (int l = 1; l <= 150; l++) begin
      for (int f = 0; f < 4; f++) begin
        run_case(l, f[1], f[0], 1'b0);
      end
    end
    report();
  end
endmodule